// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter with Clock Pass-Through

This block turns a pair of parallel audio samples (left and right) into a three-wire serial stream: a bit clock, a word clock that marks the channel, and a data line. The word length is 16, 18, 20 or 24 bits, sent most significant bit first. Everything runs on one master clock. All edges of the serial clocks are produced or detected in that clock domain.

A 2-bit format select picks the clock source. In the internal formats the block divides the master clock down to a bit clock and sends 64 bit periods per stereo frame. Each channel word sits at the end (right-aligned) of its 32-bit half frame. In the pass-through format the block takes a bit clock and a frame sync from an upstream source that shares the master clock. It sends out the inverted bit clock and uses the frame sync, delayed by two and a half input bit periods, as its word clock. The data is then placed directly after each word-clock edge (left-aligned), because the half-frame length is not known in advance. The format and the word length are static settings, changed only while the block is in reset.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, `bclk_out`, `lrck_out` and `sdata_out` are all 0, whatever the other inputs do.
- R2: With `fmt_sel` at 0, 1 or 3 (internal clocking), `bclk_out` is a square wave with a period of 2*HALF_DIV master clocks (4 by default), and one word-clock period spans exactly 64 of its falling edges.
- R3: In internal clocking, number the falling edges of `bclk_out` after reset 0, 1, 2 and so on, and take bit slot k = edge number modulo 64. `lrck_out` is 1 (left) for slots 0..31 and 0 (right) for slots 32..63. It changes only together with a falling edge of `bclk_out`.
- R4: `wlen_sel` selects the word length N: 0 = 16, 1 = 18, 2 = 20, 3 = 24. The word is bits [N-1:0] of the sample input. In internal clocking, slot s of a half frame (s = 0..31) carries word bit 31-s when 31-s < N, and 0 otherwise. Data changes only on a falling edge of `bclk_out`.
- R5: The sample inputs and `wlen_sel` are captured at the start of the left half frame. Changes made later in the frame do not affect the bits sent in that frame.
- R6: `fmt_sel` = 2 selects pass-through. Values 0, 1 and 3 all select internal clocking with identical output.
- R7: In pass-through, `bclk_out` equals the inverse of `pt_bclk_in` one master clock later.
- R8: In pass-through, `lrck_out` follows `pt_sync_in` delayed by 2.5 periods of `pt_bclk_in`. It is updated at each rising edge of `pt_bclk_in` with the sync value sampled two rising edges earlier. With a 4-high/4-low input clock and the sync changing on input falling edges, this is a delay of 20 master clocks.
- R9: In pass-through, a slot counter restarts at 0 on the input rising edge where `lrck_out` changes, then counts up and saturates at 31. Slot s carries word bit N-1-s when that index is at least 0, and 0 otherwise.
- R10: In pass-through, the samples and the length are captured on the input rising edge where `lrck_out` rises. Later input changes do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_sel | input | 2 | Clocking format: 2 = pass-through, others = internal |
| wlen_sel | input | 2 | Word length: 16/18/20/24 bits for 0..3 |
| left_in | input | SAMPLE_W | Left channel sample, word in the low bits |
| right_in | input | SAMPLE_W | Right channel sample, word in the low bits |
| pt_bclk_in | input | 1 | Upstream bit clock, synchronous to `clk` |
| pt_sync_in | input | 1 | Upstream frame sync, synchronous to `clk` |
| bclk_out | output | 1 | Serial bit clock |
| lrck_out | output | 1 | Word clock, 1 = left channel |
| sdata_out | output | 1 | Serial data, MSB first |

## Verification
The bound checker watches four things on every cycle. It checks that the outputs stay quiet in reset. It checks that the pass-through bit clock is the inverse of the input, one cycle late. It checks that the word clock and the data line move only together with a falling output bit clock, in either format. The bench alone can show the right values: the bit position and zero padding in each slot, the 64-slot frame count and the clock period, the 20-cycle sync delay, and the frame-start capture that protects a word from input changes made mid-frame.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_VAR    = 2'd1,
    FMT_PASS   = 2'd2,
    FMT_FIX48  = 2'd3
  } fmt_e;

  // Word length in bits for each length select code
  function automatic logic [4:0] word_len(input logic [1:0] sel);
    logic [4:0] n;
    case (sel)
      2'd0:    n = 5'd16;
      2'd1:    n = 5'd18;
      2'd2:    n = 5'd20;
      default: n = 5'd24;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aud_ser_clkgen.sv
// Internal bit-clock divider and frame slot counter
module aud_ser_clkgen #(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned HALF_SLOTS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic fall_stb,
  output logic lr_next
);
  localparam int unsigned DW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned SW  = $clog2(HALF_SLOTS) + 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          bclk_q, bclk_d;
  logic [SW-1:0] bit_q, bit_d;
  logic          tick;

  always_comb begin
    tick     = en && (div_q == DIV_LAST);
    div_d    = div_q;
    if (en) div_d = tick ? '0 : div_q + 1'b1;
    bclk_d   = tick ? ~bclk_q : bclk_q;
    fall_stb = tick && bclk_q;
    bit_d    = fall_stb ? bit_q + 1'b1 : bit_q;
    lr_next  = ~bit_d[SW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
      bit_q  <= '1;
    end else begin
      div_q  <= div_d;
      bclk_q <= bclk_d;
      bit_q  <= bit_d;
    end
  end

  assign bclk = bclk_q;

endmodule

// File: rtl/aud_ser_ptsync.sv
// Pass-through: inverted bit clock and a rising-edge sync delay line
module aud_ser_ptsync (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_in,
  input  logic sync_in,
  output logic bclk_inv,
  output logic rise_stb,
  output logic lr_next
);
  logic prev_q, inv_q, s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    rise_stb = en && bclk_in && !prev_q;
    s1_d     = rise_stb ? sync_in : s1_q;
    s2_d     = rise_stb ? s1_q    : s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      inv_q  <= 1'b0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
    end else begin
      prev_q <= bclk_in;
      inv_q  <= ~bclk_in;
      s1_q   <= s1_d;
      s2_q   <= s2_d;
    end
  end

  assign bclk_inv = inv_q;
  // third stage of the delay is the word-clock register in the shifter
  assign lr_next  = s2_q;

endmodule

// File: rtl/aud_ser_shifter.sv
// Slot counter, frame-start capture and bit selection
module aud_ser_shifter
  import aud_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned HALF_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                lr_next,
  input  logic                right_align,
  input  logic [1:0]          wlen_sel,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                lr,
  output logic                sd
);
  localparam int unsigned SLOT_W = $clog2(HALF_SLOTS);
  localparam int unsigned IDX_W  = $clog2(SAMPLE_W);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(HALF_SLOTS - 1);

  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [SAMPLE_W-1:0] lw_q, rw_q, lw_d, rw_d;
  logic [1:0]          ws_q, ws_d;
  logic                lr_q, lr_d, sd_q, sd_d;
  logic                start_l;
  logic [SAMPLE_W-1:0] word;
  logic [4:0]          nb;
  int                  pos;
  logic                bit_v;

  always_comb begin
    start_l = adv && lr_next && !lr_q;
    lw_d    = start_l ? left_in  : lw_q;
    rw_d    = start_l ? right_in : rw_q;
    ws_d    = start_l ? wlen_sel : ws_q;
    slot_d  = slot_q;
    if (adv) begin
      if (lr_next != lr_q)        slot_d = '0;
      else if (slot_q != SLOT_LAST) slot_d = slot_q + 1'b1;
    end
    word = lr_next ? lw_d : rw_d;
    nb   = word_len(ws_d);
    if (right_align) pos = int'(HALF_SLOTS) - 1 - int'(slot_d);
    else             pos = int'(nb) - 1 - int'(slot_d);
    bit_v = 1'b0;
    if (pos >= 0 && pos < int'(nb)) bit_v = word[pos[IDX_W-1:0]];
    lr_d = adv ? lr_next : lr_q;
    sd_d = adv ? bit_v   : sd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      lw_q   <= '0;
      rw_q   <= '0;
      ws_q   <= '0;
      lr_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      lw_q   <= lw_d;
      rw_q   <= rw_d;
      ws_q   <= ws_d;
      lr_q   <= lr_d;
      sd_q   <= sd_d;
    end
  end

  assign lr = lr_q;
  assign sd = sd_q;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned HALF_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                pt_bclk_in,
  input  logic                pt_sync_in,
  output logic                bclk_out,
  output logic                lrck_out,
  output logic                sdata_out
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       pass_mode;
  logic       int_bclk, int_fall, int_lr;
  logic       pt_bclk, pt_rise, pt_lr;
  logic       adv, lr_sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign pass_mode = (fmt_e'(fmt_sel) == FMT_PASS);

  aud_ser_clkgen #(.HALF_DIV(HALF_DIV), .HALF_SLOTS(HALF_SLOTS)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (!pass_mode),
    .bclk     (int_bclk),
    .fall_stb (int_fall),
    .lr_next  (int_lr)
  );

  aud_ser_ptsync u_ptsync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (pass_mode),
    .bclk_in  (pt_bclk_in),
    .sync_in  (pt_sync_in),
    .bclk_inv (pt_bclk),
    .rise_stb (pt_rise),
    .lr_next  (pt_lr)
  );

  always_comb begin
    adv    = pass_mode ? pt_rise : int_fall;
    lr_sel = pass_mode ? pt_lr   : int_lr;
  end

  aud_ser_shifter #(.SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .adv         (adv),
    .lr_next     (lr_sel),
    .right_align (!pass_mode),
    .wlen_sel    (wlen_sel),
    .left_in     (left_in),
    .right_in    (right_in),
    .lr          (lrck_out),
    .sd          (sdata_out)
  );

  assign bclk_out = pass_mode ? pt_bclk : int_bclk;

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_n,
  input logic [1:0] fmt_sel,
  input logic       pt_bclk_in,
  input logic       bclk_out,
  input logic       lrck_out,
  input logic       sdata_out
);

  // R1: outputs quiet in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!bclk_out && !lrck_out && !sdata_out)
        else $error("reset outputs not zero");
    end
  end

  // R7: pass-through bit clock is the inverted input, one cycle late
  p_pt_bclk_inv_r7: assert property (@(posedge clk) disable iff (!core_n)
    ($past(core_n) && fmt_sel == 2'd2 && $past(fmt_sel) == 2'd2)
      |-> (bclk_out == !$past(pt_bclk_in)));

  // R3, R8: word clock moves only with a falling output bit clock
  p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!core_n)
    ($past(core_n) && fmt_sel == $past(fmt_sel) && lrck_out != $past(lrck_out))
      |-> $fell(bclk_out));

  // R4, R9: data moves only with a falling output bit clock
  p_sd_on_fall_r4: assert property (@(posedge clk) disable iff (!core_n)
    ($past(core_n) && fmt_sel == $past(fmt_sel) && sdata_out != $past(sdata_out))
      |-> $fell(bclk_out));

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_n     (rst_core_n),
  .fmt_sel    (fmt_sel),
  .pt_bclk_in (pt_bclk_in),
  .bclk_out   (bclk_out),
  .lrck_out   (lrck_out),
  .sdata_out  (sdata_out)
);

// File: tb/aud_ser_tx_test.sv
`timescale 1ns/1ps
module aud_ser_tx_test;
  logic        clk;
  logic        rst_n;
  logic [1:0]  fmt_sel, wlen_sel;
  logic [23:0] left_in, right_in;
  logic        pt_bclk_in, pt_sync_in;
  logic        bclk_out, lrck_out, sdata_out;
  int          vec, bad;
  bit          done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  aud_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .left_in(left_in), .right_in(right_in),
    .pt_bclk_in(pt_bclk_in), .pt_sync_in(pt_sync_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out), .sdata_out(sdata_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic ref_bit(input logic [23:0] w, input int nb, input int pos);
    if (pos < 0 || pos >= nb) return 1'b0;
    return w[pos];
  endfunction

  // hold reset with wiggling inputs, R1
  task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
    rst_n = 1'b0;
    fmt_sel = f;
    wlen_sel = w;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!bclk_out && !lrck_out && !sdata_out, "R1", {bclk_out, lrck_out, sdata_out}, 0);
      pt_bclk_in = ~pt_bclk_in;
      pt_sync_in = $urandom_range(0, 1);
      left_in = $urandom;
    end
    pt_bclk_in = 1'b1;
    pt_sync_in = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_int(input logic [1:0] f, input logic [1:0] w, input int frames,
                         input logic [23:0] l0, input logic [23:0] r0);
    int cyc = 0, last = 0, fcnt = 0, nb;
    bit prev_b = 0, dirty = 0;
    logic [23:0] L = '0, R = '0;
    string tag;
    left_in = l0;
    right_in = r0;
    do_reset(f, w);
    nb = nbits(w);
    while (fcnt < frames * 64) begin
      @(negedge clk);
      cyc++;
      if (prev_b && !bclk_out) begin
        int bitn = fcnt % 64;
        int slot = bitn % 32;
        if (fcnt > 0) chk(cyc - last == 4, "R2 bclk period", cyc - last, 4);
        last = cyc;
        if (bitn == 0) begin
          L = left_in; R = right_in; dirty = 0;
        end
        tag = (f == 2'd1) ? "R3 lrck slot" : "R3/R6 lrck slot";
        chk(lrck_out == (bitn < 32), tag, lrck_out, bitn < 32);
        tag = dirty ? "R5 data after mid-frame change" : "R4 data bit";
        chk(sdata_out == ref_bit((bitn < 32) ? L : R, nb, 31 - slot), tag,
            sdata_out, ref_bit((bitn < 32) ? L : R, nb, 31 - slot));
        fcnt++;
      end
      prev_b = bclk_out;
      if ($urandom_range(0, 29) == 0) begin
        left_in = $urandom; right_in = $urandom; dirty = 1;
      end
    end
  endtask

  task automatic run_pt(input logic [1:0] w, input int half_bits, input int ncyc);
    logic hist [64];
    int bitc = 0, slot = 0, nb;
    bit prev_b = 0, prev_lr = 0, got = 0, dirty = 0, sync_v = 0;
    logic [23:0] L = '0, R = '0;
    left_in = $urandom;
    right_in = $urandom;
    do_reset(2'd2, w);
    nb = nbits(w);
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      @(negedge clk);
      hist[cyc % 64] = pt_sync_in;
      if (cyc >= 4)
        chk(bclk_out == !pt_bclk_in, "R6/R7 inverted bclk", bclk_out, !pt_bclk_in);
      if (cyc >= 40)
        chk(lrck_out == hist[(cyc - 20) % 64], "R8 sync delay", lrck_out, hist[(cyc - 20) % 64]);
      if (prev_b && !bclk_out) begin
        if (lrck_out != prev_lr) slot = 0;
        else if (slot < 31) slot++;
        if (lrck_out && !prev_lr && cyc >= 40) begin
          L = left_in; R = right_in; got = 1; dirty = 0;
        end
        if (got)
          chk(sdata_out == ref_bit(lrck_out ? L : R, nb, nb - 1 - slot),
              dirty ? "R10 capture at lrck rise" : "R9 left-aligned bit",
              sdata_out, ref_bit(lrck_out ? L : R, nb, nb - 1 - slot));
      end
      prev_b = bclk_out;
      prev_lr = lrck_out;
      // next input bit-clock level: high 4 cycles, low 4 cycles
      if (((cyc + 1) % 8) == 4) begin
        pt_bclk_in = 1'b0;
        bitc++;
        if (bitc % half_bits == 0) sync_v = ~sync_v;
        pt_sync_in = sync_v;
      end else if (((cyc + 1) % 8) == 0) begin
        pt_bclk_in = 1'b1;
      end
      if ($urandom_range(0, 40) == 0) begin
        left_in = $urandom; right_in = $urandom; dirty = 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd915));
    vec = 0; bad = 0; done = 0;
    rst_n = 1'b0;
    fmt_sel = 2'd1; wlen_sel = 2'd0;
    left_in = '0; right_in = '0;
    pt_bclk_in = 1'b0; pt_sync_in = 1'b0;
    // directed corners: all ones shows zero padding, alternating pattern shows order
    run_int(2'd1, 2'd3, 2, 24'hFFFFFF, 24'hAAAAAA);
    run_int(2'd1, 2'd0, 2, 24'hFFFFFF, 24'h00FFFF);
    run_int(2'd1, 2'd1, 3, $urandom, $urandom);
    run_int(2'd1, 2'd2, 3, $urandom, $urandom);
    run_int(2'd0, 2'd3, 2, $urandom, $urandom);
    run_int(2'd3, 2'd1, 2, $urandom, $urandom);
    run_pt(2'd3, 32, 1800);
    run_pt(2'd0, 32, 1800);
    run_pt(2'd3, 24, 1500);
    run_pt(2'd2, 24, 1500);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!bclk_out && !lrck_out && !sdata_out, "R1 final reset", {bclk_out, lrck_out, sdata_out}, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule